// File: doc/BRIEF.md
# Ring-Oscillator Entropy Word Collector

This block turns the raw outputs of a bank of free-running ring oscillators into 32-bit entropy words for a downstream consumer. The oscillator cells sit outside the block. Each cell is an adder whose carry-out is inverted and fed back as its carry-in. The block holds the two adder operand values and a run enable in registers that can be written from outside, so that synthesis keeps the cells. On every sample instant it folds all oscillator outputs into one bit by XOR and shifts that bit into a word register. Sample instants come from a programmable divider on the system clock, so samples are much slower than the oscillators toggle. When the word is complete, the block offers it to the consumer with a valid flag. The consumer retires the word with a one-cycle acknowledge.

After reset, a warm-up count must expire before any word is offered. Words completed during warm-up are thrown away. A free-running debug timer periodically copies the low byte of the held word into a debug byte and pulses a strobe.

Top module: `entropy_word_gatherer`

## Requirements
- R1: After reset, the word is 0, valid is low, the debug byte is 0, the debug strobe is low, the run enable is 1, and the operand outputs equal the parameters DEF_OPA and DEF_OPB.
- R2: A cycle with cfg_wr high loads cfg_en, cfg_opa and cfg_opb. The run_en, osc_opa and osc_opb outputs show the new values after that clock edge.
- R3: While enabled, a sample fires on the edge where the sample counter is at or above smp_interval, which is once every smp_interval+1 enabled cycles. The XOR of all 32 oscillator inputs enters the shift register at bit 0, and older bits move toward bit 31.
- R4: When 32 bits have been collected and the word may be captured, the shift register is copied to word_out (bit 31 holds the oldest bit), valid rises and collection restarts.
- R5: While valid is high and ack is low, valid stays high and word_out does not change.
- R6: No word is offered until WARMUP clock cycles have passed since reset. A word completed before then is discarded and collection restarts.
- R7: When a word completes while an earlier word is still unacknowledged, collection stalls with the full word held, and no later sample is taken until ack.
- R8: If ack arrives in the same cycle in which a completed word is waiting, the new word is captured in that cycle and valid stays high.
- R9: While run_en is low, word_valid is low, ack has no effect, and the sample counter, bit counter and shift register hold. The held word is offered again once run_en returns.
- R10: Every DBG_PERIOD cycles, dbg_byte takes bits 7:0 of word_out and dbg_stb is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for enable and operands |
| cfg_en | input | 1 | Enable value to load |
| cfg_opa | input | 32 | Operand A value to load |
| cfg_opb | input | 32 | Operand B value to load |
| smp_interval | input | 8 | Sample interval minus one, in clocks |
| osc_in | input | 32 | Oscillator outputs |
| ack | input | 1 | Consumer retires the offered word |
| run_en | output | 1 | Current enable |
| osc_opa | output | 32 | Operand A to the oscillator adders |
| osc_opb | output | 32 | Operand B to the oscillator adders |
| word_out | output | 32 | Held entropy word |
| word_valid | output | 1 | Word offered to the consumer |
| dbg_byte | output | 8 | Debug snapshot of the word's low byte |
| dbg_stb | output | 1 | One-cycle pulse on debug update |

## Verification
Two events can fall in the same cycle: the consumer acknowledging the held word, and the collector finishing a new word. The bench drives random acknowledges against short sample intervals. This makes completions meet pending words often, in both the stalled case and the same-cycle case. A cycle-accurate bench model judges every cycle, and it must see at least one stall and at least one same-cycle ack with capture. Enable drops are mixed in, so that the hold rule is also tested against a pending word.

// File: rtl/entropy_word_gatherer.sv
module entropy_word_gatherer #(
  parameter int NOSC = 32,
  parameter int WORD_W = 32,
  parameter int CNT_W = 8,
  parameter int DBG_W = 8,
  parameter int TMR_W = 32,
  parameter int WARMUP = 1000,
  parameter int DBG_PERIOD = 100000,
  parameter logic [WORD_W-1:0] DEF_OPA = 32'h0f0f_a5a5,
  parameter logic [WORD_W-1:0] DEF_OPB = 32'h3c3c_5a5a
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [WORD_W-1:0] cfg_opa,
  input  logic [WORD_W-1:0] cfg_opb,
  input  logic [CNT_W-1:0]  smp_interval,
  input  logic [NOSC-1:0]   osc_in,
  input  logic              ack,
  output logic              run_en,
  output logic [WORD_W-1:0] osc_opa,
  output logic [WORD_W-1:0] osc_opb,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic [DBG_W-1:0]  dbg_byte,
  output logic              dbg_stb
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [TMR_W-1:0] WU_INIT = TMR_W'(WARMUP);
  localparam logic [TMR_W-1:0] DBG_LAST = TMR_W'(DBG_PERIOD - 1);

  logic              en_q;
  logic [WORD_W-1:0] opa_q, opb_q, sh_q, word_q;
  logic [CNT_W-1:0]  scnt_q, bcnt_q;
  logic              val_q;
  logic [TMR_W-1:0]  wu_q, dc_q;
  logic [DBG_W-1:0]  db_q;
  logic              ds_q;

  wire full      = (bcnt_q == FULL);
  wire warm_done = (wu_q == '0);
  wire tick      = (scnt_q >= smp_interval);
  wire take      = val_q & en_q & ack;
  wire capture   = en_q & full & warm_done & (~val_q | ack);
  wire discard   = en_q & full & ~warm_done;
  wire shift     = en_q & ~full & tick;
  wire ent_bit   = ^osc_in;

  assign run_en     = en_q;
  assign osc_opa    = opa_q;
  assign osc_opb    = opb_q;
  assign word_out   = word_q;
  assign word_valid = val_q & en_q;
  assign dbg_byte   = db_q;
  assign dbg_stb    = ds_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      opa_q <= DEF_OPA;
      opb_q <= DEF_OPB;
    end else if (cfg_wr) begin
      en_q  <= cfg_en;
      opa_q <= cfg_opa;
      opb_q <= cfg_opb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
    end else if (en_q) begin
      scnt_q <= tick ? '0 : scnt_q + 1'b1;
      if (shift) begin
        sh_q   <= {sh_q[WORD_W-2:0], ent_bit};
        bcnt_q <= bcnt_q + 1'b1;
      end else if (capture || discard) begin
        bcnt_q <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      val_q  <= 1'b0;
    end else if (capture) begin
      word_q <= sh_q;
      val_q  <= 1'b1;
    end else if (take) begin
      val_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wu_q <= WU_INIT;
    else if (!warm_done) wu_q <= wu_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q <= '0;
      db_q <= '0;
      ds_q <= 1'b0;
    end else if (dc_q >= DBG_LAST) begin
      dc_q <= '0;
      db_q <= word_q[DBG_W-1:0];
      ds_q <= 1'b1;
    end else begin
      dc_q <= dc_q + 1'b1;
      ds_q <= 1'b0;
    end
  end

  // R5
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !ack && !cfg_wr) |=> (word_valid && $stable(word_out)));

  // R6
  warm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_done |-> !val_q);

  // R7
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= FULL);

  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> ($stable(bcnt_q) && $stable(sh_q) && $stable(scnt_q)));

  // R9
  pause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !word_valid);

  // R10
  dbg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_stb |=> !dbg_stb);
endmodule

// File: tb/entropy_word_gatherer_test.sv
`timescale 1ns/1ps
module entropy_word_gatherer_test;
  localparam int WU = 300;
  localparam int DP = 97;
  localparam logic [31:0] DA = 32'h0f0f_a5a5;
  localparam logic [31:0] DB = 32'h3c3c_5a5a;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_en = 1'b1, ack = 1'b0;
  logic [31:0] cfg_opa = '0, cfg_opb = '0, osc_in = '0;
  logic [7:0] smp_interval = 8'd0;
  logic run_en, word_valid, dbg_stb;
  logic [31:0] osc_opa, osc_opb, word_out;
  logic [7:0] dbg_byte;

  int checks = 0, fails = 0;
  bit done = 0;

  entropy_word_gatherer #(.WARMUP(WU), .DBG_PERIOD(DP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_opa(cfg_opa), .cfg_opb(cfg_opb), .smp_interval(smp_interval),
    .osc_in(osc_in), .ack(ack), .run_en(run_en), .osc_opa(osc_opa),
    .osc_opb(osc_opb), .word_out(word_out), .word_valid(word_valid),
    .dbg_byte(dbg_byte), .dbg_stb(dbg_stb));

  always #2.5 clk = ~clk;

  // bench model, built from the requirements
  logic m_en; logic [31:0] m_opa, m_opb, m_sh, m_word;
  int m_scnt, m_bcnt, m_wu, m_dc;
  logic m_val, m_ds; logic [7:0] m_db;
  int n_stall = 0, n_coll = 0, n_disc = 0;

  function automatic logic xor_all(input logic [31:0] v);
    return ^v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 1; m_opa = DA; m_opb = DB; m_sh = 0; m_word = 0;
      m_scnt = 0; m_bcnt = 0; m_wu = WU; m_dc = 0; m_val = 0; m_ds = 0; m_db = 0;
    end else begin
      logic o_en; int o_wu; logic [31:0] o_word;
      o_en = m_en; o_wu = m_wu; o_word = m_word;
      if (m_wu != 0) m_wu--;
      if (m_dc >= DP - 1) begin m_dc = 0; m_db = o_word[7:0]; m_ds = 1; end
      else begin m_dc++; m_ds = 0; end
      if (cfg_wr) begin m_en = cfg_en; m_opa = cfg_opa; m_opb = cfg_opb; end
      if (o_en) begin
        logic fire;
        fire = (m_scnt >= smp_interval);
        m_scnt = fire ? 0 : m_scnt + 1;
        if (m_bcnt == 32) begin
          if (o_wu != 0) begin m_bcnt = 0; n_disc++; end
          else if (!m_val || ack) begin
            if (m_val) n_coll++;
            m_word = m_sh; m_val = 1; m_bcnt = 0;
          end else n_stall++;
        end else begin
          if (m_val && ack) m_val = 0;
          if (fire) begin m_sh = {m_sh[30:0], xor_all(osc_in)}; m_bcnt++; end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #900000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 word", word_out, 0); chk("R1 valid", {31'b0, word_valid}, 0);
    chk("R1 dbg", {24'b0, dbg_byte}, 0); chk("R1 stb", {31'b0, dbg_stb}, 0);
    chk("R1 en", {31'b0, run_en}, 1); chk("R1 opa", osc_opa, DA); chk("R1 opb", osc_opb, DB);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      osc_in = $urandom;
      cfg_wr = 1'b0;
      ack = 1'b0;
      if (cyc < 250) smp_interval = 8'd0;
      else if (cyc % 1500 < 700) smp_interval = 8'($urandom_range(0, 1));
      else smp_interval = 8'($urandom_range(0, 3));
      if (cyc > 400 && $urandom_range(0, 99) < 2) begin
        cfg_wr = 1'b1; cfg_en = ($urandom_range(0, 3) != 0);
        cfg_opa = $urandom; cfg_opb = $urandom;
      end
      if (cyc > 300 && !m_en && $urandom_range(0, 9) < 3) begin
        cfg_wr = 1'b1; cfg_en = 1'b1;
      end
      if ($urandom_range(0, 99) < ((cyc % 1500 < 700) ? 8 : 35)) ack = 1'b1;
      @(negedge clk);
      chk("R3 R4 word", word_out, m_word);
      chk("R5 valid", {31'b0, word_valid}, {31'b0, m_val & m_en});
      chk("R2 en", {31'b0, run_en}, {31'b0, m_en});
      chk("R2 opa", osc_opa, m_opa);
      chk("R2 opb", osc_opb, m_opb);
      chk("R10 dbg", {24'b0, dbg_byte}, {24'b0, m_db});
      chk("R10 stb", {31'b0, dbg_stb}, {31'b0, m_ds});
      if (cyc < WU - 2) chk("R6 warm", {31'b0, word_valid}, 0);
      if (!run_en) chk("R9 paused", {31'b0, word_valid}, 0);
    end
    chk("R6 discards seen", {31'b0, n_disc > 0}, 1);
    chk("R7 stalls seen", {31'b0, n_stall > 0}, 1);
    chk("R8 collisions seen", {31'b0, n_coll > 0}, 1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule